// File: doc/BRIEF.md
# Parity-Protected Fault and Position Status Bank

This block keeps four read-only status bytes that a serial slave port hands out to a host controller. It samples raw fault lines, a watchdog event pulse and a step position. Each byte carries a parity bit in its top bit. Bridge overcurrent and thermal-shutdown faults are held until the host has read them. The block also drives an active-low error pin.

Every status update happens on the system clock, and only while the chip-select-high indication is asserted. During a transfer (chip select low) all bytes and the error pin stay frozen, so the host never sees a value change in the middle of a frame.

The serial port reports two things: a read strobe carrying the register address, and writes to the watchdog-enable bit. A read of a latching byte arms a clear. The clear takes effect at the first clock edge with chip select high. Any fault still present at that edge is captured again, so it is not lost.

Top module: `status_bank_top`

## Requirements
- R1: After reset all four status bytes read 00h and the error pin `errN` is high.
- R2: In every status byte, bit 7 equals the XOR of bits 6:0, so the whole byte holds an even number of ones.
- R3: The byte at address 04h is live: bit 0 is charge-pump failure, bit 1 is thermal warning, bit 2 is the watchdog flag, bit 3 is open coil X, bit 4 is open coil Y, and bits 6:5 are 0. It shows the input values from the last clock edge with chip select high.
- R4: The byte at address 07h is live and carries the 7-bit step position in bits 6:0.
- R5: The byte at 05h holds `ovcX[3:0]` in bits 3:0. The byte at 06h holds `ovcY[3:0]` in bits 3:0 and thermal shutdown in bit 4. Once a bit is set in either byte, it stays set after its input returns to 0.
- R6: On any clock edge where `csHigh` is 0, no status byte and not the error pin changes.
- R7: A read strobe at address 05h or 06h clears only that byte, at the first clock edge with `csHigh` = 1. At that edge the byte loads the faults still present. A read strobe at any other address clears nothing.
- R8: A `wdEvent` pulse sets the watchdog flag. The flag stays set until a write of 0 to the watchdog-enable bit, which takes effect at the first clock edge with `csHigh` = 1. A write of 1 leaves the flag set.
- R9: `errN` is low exactly when a latched fault bit (any bit of 05h or 06h, or the watchdog flag) is set. It changes on the same edge as the status bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csHigh | input | 1 | Chip select is high (serial port idle) |
| rdStb | input | 1 | One-cycle read strobe from the serial port |
| rdAddr | input | 5 | Register address of the read |
| wdEnWr | input | 1 | One-cycle write strobe for the watchdog-enable bit |
| wdEnVal | input | 1 | Value written to the watchdog-enable bit |
| cpFail | input | 1 | Charge-pump failure (live) |
| thermWarn | input | 1 | Thermal warning (live) |
| wdEvent | input | 1 | Watchdog time-out event pulse |
| openX | input | 1 | Open coil X (live) |
| openY | input | 1 | Open coil Y (live) |
| ovcX | input | 4 | Overcurrent flags for bridge X |
| ovcY | input | 4 | Overcurrent flags for bridge Y |
| thermShut | input | 1 | Thermal shutdown |
| stepPos | input | 7 | Step position |
| stsFault | output | 8 | Status byte 04h |
| stsBridgeX | output | 8 | Status byte 05h |
| stsBridgeY | output | 8 | Status byte 06h |
| stsPosition | output | 8 | Status byte 07h |
| errN | output | 1 | Active-low error pin |

## Verification
A live input is sampled on a clock edge with `csHigh` high and appears on the outputs after that one edge. A clear or watchdog-enable write is armed while chip select is low and shows after the first edge with `csHigh` high, so reads are due one edge after chip select rises. The bench changes inputs on the falling edge, then waits for exactly one rising edge and samples on the next falling edge. While chip select is low, it samples after several edges to confirm that nothing has moved.

// File: rtl/status_bank_pkg.sv
package status_bank_pkg;
  localparam int LAT_N = 2;

  typedef struct packed {
    logic             upd;
    logic [LAT_N-1:0] clrLat;
    logic             clrWd;
  } ctlStrobes_t;
endpackage

// File: rtl/status_bank_ctrl.sv
module status_bank_ctrl
  import status_bank_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csHigh,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wdEnWr,
  input  logic              wdEnVal,
  output ctlStrobes_t       ctl
);
  logic [LAT_N-1:0] rdHit;
  logic [LAT_N-1:0] clrArm;
  logic             wdArm;

  genvar k;
  generate
    for (k = 0; k < LAT_N; k++) begin : g_arm
      localparam logic [ADDR_W-1:0] LAT_ADDR = ADDR_W'(BASE_ADDR + 1 + k);

      assign rdHit[k] = rdStb && (rdAddr == LAT_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clrArm[k] <= 1'b0;
        else        clrArm[k] <= (clrArm[k] && !csHigh) || rdHit[k];
      end

      // R7: a read of a latching byte must leave a pending clear behind
      a_r7_arm_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rdHit[k] |=> clrArm[k]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdArm <= 1'b0;
    else if (wdEnWr) wdArm <= !wdEnVal;
    else if (csHigh) wdArm <= 1'b0;
  end

  assign ctl.upd    = csHigh;
  assign ctl.clrLat = clrArm & {LAT_N{csHigh}};
  assign ctl.clrWd  = wdArm && csHigh;

  // R8: a write of 1 cancels any pending flag clear
  a_r8_one_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wdEnWr && wdEnVal) |=> !wdArm);
endmodule

// File: rtl/status_bank_dp.sv
module status_bank_dp
  import status_bank_pkg::*;
#(
  parameter int POS_W = 7,
  parameter int OVC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobes_t      ctl,
  input  logic             cpFail,
  input  logic             thermWarn,
  input  logic             wdEvent,
  input  logic             openX,
  input  logic             openY,
  input  logic [OVC_W-1:0] ovcX,
  input  logic [OVC_W-1:0] ovcY,
  input  logic             thermShut,
  input  logic [POS_W-1:0] stepPos,
  output logic [POS_W:0]   stsFault,
  output logic [POS_W:0]   stsBridgeX,
  output logic [POS_W:0]   stsBridgeY,
  output logic [POS_W:0]   stsPosition,
  output logic             errN
);
  localparam int DATA_W = POS_W;
  localparam int BYTE_W = POS_W + 1;

  logic [DATA_W-1:0] latRaw  [LAT_N];
  logic [DATA_W-1:0] latNext [LAT_N];
  logic [BYTE_W-1:0] latByte [LAT_N];
  logic [DATA_W-1:0] liveNext;
  logic              wdFlag;
  logic              wdNext;
  logic              errNext;

  assign latRaw[0] = {{(DATA_W-OVC_W){1'b0}}, ovcX};
  assign latRaw[1] = {{(DATA_W-OVC_W-1){1'b0}}, thermShut, ovcY};

  genvar k;
  generate
    for (k = 0; k < LAT_N; k++) begin : g_lat
      assign latNext[k] = ctl.clrLat[k] ? latRaw[k]
                                        : (latByte[k][DATA_W-1:0] | latRaw[k]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latByte[k] <= '0;
        else if (ctl.upd) latByte[k] <= {^latNext[k], latNext[k]};
      end

      // R5: without a clear, a set bit is never dropped
      a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.upd && !ctl.clrLat[k]) |=>
          ((latByte[k][DATA_W-1:0] & $past(latByte[k][DATA_W-1:0]))
            == $past(latByte[k][DATA_W-1:0])));
    end
  endgenerate

  assign wdNext   = ctl.clrWd ? wdEvent : (wdFlag || wdEvent);
  assign liveNext = {{(DATA_W-5){1'b0}}, openY, openX, wdNext, thermWarn, cpFail};
  assign errNext  = !((|latNext[0]) || (|latNext[1]) || wdNext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdFlag      <= 1'b0;
      stsFault    <= '0;
      stsPosition <= '0;
      errN        <= 1'b1;
    end else if (ctl.upd) begin
      wdFlag      <= wdNext;
      stsFault    <= {^liveNext, liveNext};
      stsPosition <= {^stepPos, stepPos};
      errN        <= errNext;
    end
  end

  assign stsBridgeX = latByte[0];
  assign stsBridgeY = latByte[1];

  // R2: every published byte has even overall parity
  a_r2_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    !(^stsFault) && !(^stsBridgeX) && !(^stsBridgeY) && !(^stsPosition));

  // R6: nothing moves on an edge taken while chip select is low
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.upd |=> ($stable(stsFault) && $stable(stsBridgeX) && $stable(stsBridgeY)
                  && $stable(stsPosition) && $stable(errN)));

  // R9: the pin agrees with the latched bits held in the bytes
  a_r9_err_pin: assert property (@(posedge clk) disable iff (!rst_n)
    errN == !((|stsBridgeX[DATA_W-1:0]) || (|stsBridgeY[DATA_W-1:0]) || stsFault[2]));

  // R8: the watchdog flag only falls on an edge carrying a clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.upd && !ctl.clrWd && wdFlag) |=> wdFlag);
endmodule

// File: rtl/status_bank_top.sv
module status_bank_top
  import status_bank_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 4,
  parameter int POS_W     = 7,
  parameter int OVC_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csHigh,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wdEnWr,
  input  logic              wdEnVal,
  input  logic              cpFail,
  input  logic              thermWarn,
  input  logic              wdEvent,
  input  logic              openX,
  input  logic              openY,
  input  logic [OVC_W-1:0]  ovcX,
  input  logic [OVC_W-1:0]  ovcY,
  input  logic              thermShut,
  input  logic [POS_W-1:0]  stepPos,
  output logic [POS_W:0]    stsFault,
  output logic [POS_W:0]    stsBridgeX,
  output logic [POS_W:0]    stsBridgeY,
  output logic [POS_W:0]    stsPosition,
  output logic              errN
);
  ctlStrobes_t ctl;

  status_bank_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csHigh(csHigh), .rdStb(rdStb), .rdAddr(rdAddr),
    .wdEnWr(wdEnWr), .wdEnVal(wdEnVal), .ctl(ctl)
  );

  status_bank_dp #(.POS_W(POS_W), .OVC_W(OVC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cpFail(cpFail), .thermWarn(thermWarn),
    .wdEvent(wdEvent), .openX(openX), .openY(openY), .ovcX(ovcX), .ovcY(ovcY),
    .thermShut(thermShut), .stepPos(stepPos), .stsFault(stsFault),
    .stsBridgeX(stsBridgeX), .stsBridgeY(stsBridgeY), .stsPosition(stsPosition),
    .errN(errN)
  );
endmodule

// File: tb/tb_status_bank_top.sv
`timescale 1ns/1ps
module tb_status_bank_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csHigh = 1'b1;
  logic       rdStb = 1'b0;
  logic [4:0] rdAddr = '0;
  logic       wdEnWr = 1'b0, wdEnVal = 1'b0;
  logic       cpFail = 1'b0, thermWarn = 1'b0, wdEvent = 1'b0, openX = 1'b0, openY = 1'b0;
  logic [3:0] ovcX = '0, ovcY = '0;
  logic       thermShut = 1'b0;
  logic [6:0] stepPos = '0;
  logic [7:0] stsFault, stsBridgeX, stsBridgeY, stsPosition;
  logic       errN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  status_bank_top dut (
    .clk(clk), .rst_n(rst_n), .csHigh(csHigh), .rdStb(rdStb), .rdAddr(rdAddr),
    .wdEnWr(wdEnWr), .wdEnVal(wdEnVal), .cpFail(cpFail), .thermWarn(thermWarn),
    .wdEvent(wdEvent), .openX(openX), .openY(openY), .ovcX(ovcX), .ovcY(ovcY),
    .thermShut(thermShut), .stepPos(stepPos), .stsFault(stsFault),
    .stsBridgeX(stsBridgeX), .stsBridgeY(stsBridgeY), .stsPosition(stsPosition),
    .errN(errN)
  );

  // {live {openY,openX,thermWarn,cpFail}, pos, expected 04h, expected 07h}
  localparam logic [26:0] VEC [6] = '{
    {4'h0, 7'h00, 8'h00, 8'h00},
    {4'h1, 7'h01, 8'h81, 8'h81},
    {4'hA, 7'h7F, 8'h12, 8'hFF},
    {4'h4, 7'h55, 8'h88, 8'h55},
    {4'hF, 7'h2A, 8'h1B, 8'hAA},
    {4'h8, 7'h40, 8'h90, 8'hC0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lowRead(input logic [4:0] a);
    csHigh = 1'b0; rdStb = 1'b1; rdAddr = a;
    step();
    rdStb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset 04h", stsFault, 8'h00);
    check("R1 reset 05h", stsBridgeX, 8'h00);
    check("R1 reset 06h", stsBridgeY, 8'h00);
    check("R1 reset 07h", stsPosition, 8'h00);
    check("R1 reset errN", {7'd0, errN}, 8'h01);

    for (int i = 0; i < 6; i++) begin
      {openY, openX, thermWarn, cpFail} = VEC[i][26:23];
      stepPos = VEC[i][22:16];
      step();
      check($sformatf("R3 R2 live byte vec %0d", i), stsFault, VEC[i][15:8]);
      check($sformatf("R4 R2 position vec %0d", i), stsPosition, VEC[i][7:0]);
    end
    {openY, openX, thermWarn, cpFail} = 4'h0; stepPos = '0;
    step();

    // R5 latch and R9 pin
    ovcX = 4'h5; step();
    ovcX = 4'h0; step();
    check("R5 05h sticky", stsBridgeX, 8'h05);
    check("R5 06h untouched", stsBridgeY, 8'h00);
    check("R9 errN low", {7'd0, errN}, 8'h00);

    // R6 freeze while chip select low
    csHigh = 1'b0; ovcY = 4'h1; thermShut = 1'b1; stepPos = 7'h03;
    repeat (3) step();
    check("R6 06h frozen", stsBridgeY, 8'h00);
    check("R6 07h frozen", stsPosition, 8'h00);
    csHigh = 1'b1; step();
    ovcY = 4'h0; thermShut = 1'b0;
    check("R5 06h capture", stsBridgeY, 8'h11);
    check("R4 07h after cs high", stsPosition, 8'h03);

    // R7 read of another address clears nothing
    lowRead(5'h07); csHigh = 1'b1; step();
    check("R7 other addr 05h", stsBridgeX, 8'h05);
    check("R7 other addr 06h", stsBridgeY, 8'h11);

    // R7 clear with recapture
    ovcX = 4'h2;
    lowRead(5'h05);
    check("R6 05h held during read", stsBridgeX, 8'h05);
    csHigh = 1'b1; step();
    check("R7 recapture 05h", stsBridgeX, 8'h82);
    check("R7 06h kept", stsBridgeY, 8'h11);
    step();
    check("R7 no second clear", stsBridgeX, 8'h82);
    ovcX = 4'h0;
    lowRead(5'h05); csHigh = 1'b1; step();
    check("R7 05h cleared", stsBridgeX, 8'h00);
    check("R9 errN low by 06h", {7'd0, errN}, 8'h00);
    lowRead(5'h06); csHigh = 1'b1; step();
    check("R7 06h cleared", stsBridgeY, 8'h00);
    check("R9 errN released", {7'd0, errN}, 8'h01);

    // R8 watchdog flag
    wdEvent = 1'b1; step();
    wdEvent = 1'b0; step();
    check("R8 flag set", stsFault, 8'h84);
    check("R9 errN on flag", {7'd0, errN}, 8'h00);
    csHigh = 1'b0; wdEnWr = 1'b1; wdEnVal = 1'b1; step();
    wdEnWr = 1'b0; csHigh = 1'b1; step();
    check("R8 write one keeps", stsFault, 8'h84);
    csHigh = 1'b0; wdEnWr = 1'b1; wdEnVal = 1'b0; step();
    wdEnWr = 1'b0;
    check("R8 held until cs high", stsFault, 8'h84);
    csHigh = 1'b1; step();
    check("R8 write zero clears", stsFault, 8'h00);
    check("R9 errN after clear", {7'd0, errN}, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule